// File: doc/BRIEF.md
# UART Shared Interrupt Request Logic

This block merges the three interrupt causes of one UART channel into a single level request line for the interrupt controller. The causes are: the transmit holding buffer is empty, the receive buffer holds the chosen number of characters, and a receive error has been latched. Each cause has its own enable bit. A threshold bit decides whether the receive cause needs one buffered character or two. To find out which cause fired, software reads the status and error flags. The block returns no cause code.

The block holds the control register and the sticky receive error flags. Control fields reset to zero, so every cause starts masked. The receive path raises one-cycle set pulses for parity, framing and overrun errors. Each pulse latches its flag, and the flag stays set until software writes a 1 to that bit. The transmit-empty, one-character and two-character status levels come from the rest of the UART and are used as they are.

Encoding: control bit 0 enables transmit-empty, bit 1 enables receive-full, bit 2 enables receive-error, and bit 3 selects the two-character threshold. Error flag bit 0 is parity, bit 1 is framing and bit 2 is overrun.

Top module: `uart_irq`

## Requirements
- R1: `irq_o` is the OR of the three masked causes. It is a level that stays high while any enabled cause remains true and falls once none does.
- R2: The transmit cause is active whenever control bit 0 and `tx_empty_i` are both 1. It does not matter whether the enable is written while the buffer is already empty or the buffer empties while the enable is already set.
- R3: With control bit 3 at 0 and control bit 1 at 1, the receive cause follows `rx_one_i`.
- R4: With control bit 3 at 1 and control bit 1 at 1, the receive cause follows `rx_two_i`, and `rx_one_i` alone does not raise `irq_o`.
- R5: With control bit 2 at 1, `irq_o` is high in the same cycle that any error flag first reads 1, which is one clock after its set pulse.
- R6: After reset, `ctrl_o` is 0, `err_flags_o` is 0 and `irq_o` is 0, even if every status input is 1.
- R7: A set pulse on `err_set_i[k]` makes `err_flags_o[k]` read 1 from the next clock onward. The flag holds until it is cleared by a write.
- R8: When `err_clr_we_i` is high, only the flag bits whose `err_clr_i` bit is 1 are cleared. Bits written with 0 keep their value.
- R9: If a set pulse and a clear write hit the same flag bit in the same cycle, the flag reads 1 afterwards.
- R10: A write with `ctrl_we_i` high loads `ctrl_wdata_i` into the control register. The new value appears on `ctrl_o` and takes effect on `irq_o` from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control write data: {thresh_two, err_en, rx_en, tx_en} |
| err_clr_we_i | input | 1 | Error flag write strobe (write 1 to clear) |
| err_clr_i | input | ERR_W | Clear mask: {overrun, framing, parity} |
| err_set_i | input | ERR_W | Error set pulses from the receive path |
| tx_empty_i | input | 1 | Transmit holding buffer empty |
| rx_one_i | input | 1 | At least one character in the receive buffer |
| rx_two_i | input | 1 | Two characters in the receive buffer |
| ctrl_o | output | 4 | Control register readback |
| err_flags_o | output | ERR_W | Sticky error flags |
| irq_o | output | 1 | Shared level interrupt request |

## Verification
Enable and status are raised in both orders. A design that fires only on an edge would miss the case where the enable is written after the buffer is already empty. With the two-character threshold selected, the bench holds a single buffered character; a threshold mux wired the wrong way round would raise the request there. On the clear path it writes clear masks with zero bits, and it collides a set pulse with a clear of the same bit. A design that clears the whole register, or lets the clear win, would then drop an error that was just reported. It also removes active causes one at a time, which exposes a request that drops early or sticks after the last cause has gone.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned CTRL_W      = 4;
  localparam int unsigned CTRL_TX_EN  = 0;
  localparam int unsigned CTRL_RX_EN  = 1;
  localparam int unsigned CTRL_ERR_EN = 2;
  localparam int unsigned CTRL_THR2   = 3;

  typedef struct packed {
    logic thresh_two;
    logic err_en;
    logic rx_en;
    logic tx_en;
  } irq_ctrl_t;
endpackage

// File: rtl/uart_irq_ctrl_reg.sv
module uart_irq_ctrl_reg
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output irq_ctrl_t         ctrl_o
);
  irq_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= irq_ctrl_t'(wdata_i);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/uart_irq_err_flag.sv
module uart_irq_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set wins over a simultaneous clear so no error is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine
  import uart_irq_pkg::*;
#(
  parameter int unsigned ERR_W = 3
) (
  input  irq_ctrl_t        ctrl_i,
  input  logic [ERR_W-1:0] err_flags_i,
  input  logic             tx_empty_i,
  input  logic             rx_one_i,
  input  logic             rx_two_i,
  output logic             irq_o
);
  logic tx_cause, rx_level, rx_cause, err_cause;

  always_comb begin
    rx_level  = ctrl_i.thresh_two ? rx_two_i : rx_one_i;
    tx_cause  = ctrl_i.tx_en  & tx_empty_i;
    rx_cause  = ctrl_i.rx_en  & rx_level;
    err_cause = ctrl_i.err_en & (|err_flags_i);
    irq_o     = tx_cause | rx_cause | err_cause;
  end
endmodule

// File: rtl/uart_irq.sv
module uart_irq
  import uart_irq_pkg::*;
#(
  parameter int unsigned ERR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              err_clr_we_i,
  input  logic [ERR_W-1:0]  err_clr_i,
  input  logic [ERR_W-1:0]  err_set_i,
  input  logic              tx_empty_i,
  input  logic              rx_one_i,
  input  logic              rx_two_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [ERR_W-1:0]  err_flags_o,
  output logic              irq_o
);
  irq_ctrl_t        ctrl;
  logic [ERR_W-1:0] flags;

  uart_irq_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl)
  );

  for (genvar k = 0; k < ERR_W; k++) begin : g_err
    uart_irq_err_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (err_set_i[k]),
      .clr_i  (err_clr_we_i & err_clr_i[k]),
      .flag_o (flags[k])
    );
  end

  uart_irq_combine #(.ERR_W(ERR_W)) u_comb (
    .ctrl_i      (ctrl),
    .err_flags_i (flags),
    .tx_empty_i  (tx_empty_i),
    .rx_one_i    (rx_one_i),
    .rx_two_i    (rx_two_i),
    .irq_o       (irq_o)
  );

  assign ctrl_o      = ctrl;
  assign err_flags_o = flags;
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
#(
  parameter int unsigned ERR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic              err_clr_we_i,
  input logic [ERR_W-1:0]  err_clr_i,
  input logic [ERR_W-1:0]  err_set_i,
  input logic              tx_empty_i,
  input logic              rx_one_i,
  input logic              rx_two_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [ERR_W-1:0]  err_flags_o,
  input logic              irq_o
);
  // R2
  tx_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[CTRL_TX_EN] && tx_empty_i) |-> irq_o);

  // R3
  rx_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[CTRL_RX_EN] && !ctrl_o[CTRL_THR2] && rx_one_i) |-> irq_o);

  // R4
  rx_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[CTRL_RX_EN] && ctrl_o[CTRL_THR2] && rx_two_i) |-> irq_o);

  // R5
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[CTRL_ERR_EN] && (err_flags_o != '0)) |-> irq_o);

  // R1
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ctrl_o[CTRL_TX_EN] && tx_empty_i) ||
               (ctrl_o[CTRL_RX_EN] && (ctrl_o[CTRL_THR2] ? rx_two_i : rx_one_i)) ||
               (ctrl_o[CTRL_ERR_EN] && (err_flags_o != '0))));

  // R7
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i != '0) |=> ((err_flags_o & $past(err_set_i)) == $past(err_set_i)));

  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_set_i == '0) && !err_clr_we_i) |=> $stable(err_flags_o));

  // R8
  clr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_we_i |=> ((err_flags_o & ~$past(err_clr_i)) ==
                      ($past(err_flags_o | err_set_i) & ~$past(err_clr_i))));

  // R10
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_o == $past(ctrl_wdata_i)));
endmodule

bind uart_irq uart_irq_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .err_clr_we_i (err_clr_we_i),
  .err_clr_i    (err_clr_i),
  .err_set_i    (err_set_i),
  .tx_empty_i   (tx_empty_i),
  .rx_one_i     (rx_one_i),
  .rx_two_i     (rx_two_i),
  .ctrl_o       (ctrl_o),
  .err_flags_o  (err_flags_o),
  .irq_o        (irq_o)
);

// File: tb/uart_irq_tb.sv
module uart_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W      = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ctrl_we = 1'b0;
  logic [3:0]       ctrl_wdata = '0;
  logic             clr_we = 1'b0;
  logic [ERR_W-1:0] clr = '0;
  logic [ERR_W-1:0] set = '0;
  logic             tx_empty = 1'b0, rx_one = 1'b0, rx_two = 1'b0;
  logic [3:0]       ctrl_o;
  logic [ERR_W-1:0] flags_o;
  logic             irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int m_ctrl  = 0;
  int m_err   = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq #(.ERR_W(ERR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .err_clr_we_i(clr_we), .err_clr_i(clr), .err_set_i(set),
    .tx_empty_i(tx_empty), .rx_one_i(rx_one), .rx_two_i(rx_two),
    .ctrl_o(ctrl_o), .err_flags_o(flags_o), .irq_o(irq_o)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 0;
      m_err  = 0;
    end else begin
      if (ctrl_we) m_ctrl = int'(ctrl_wdata);
      if (clr_we)  m_err  = m_err & ~int'(clr);
      m_err = m_err | int'(set);
    end
  end

  function automatic bit model_irq();
    bit rx_lvl;
    rx_lvl = m_ctrl[3] ? rx_two : rx_one;
    return (m_ctrl[0] && tx_empty) || (m_ctrl[1] && rx_lvl) || (m_ctrl[2] && m_err != 0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    chk("R10 ctrl model", int'(ctrl_o), m_ctrl);
    chk("R7 flags model", int'(flags_o), m_err);
    chk("R1 irq model", int'(irq_o), int'(model_irq()));
  endtask

  task automatic wr_ctrl(logic [3:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    cycle();
    ctrl_we = 1'b0;
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    tx_empty = 1'b1; rx_one = 1'b1; rx_two = 1'b1;
    repeat (3) @(negedge clk);
    // R6 defaults
    chk("R6 ctrl", int'(ctrl_o), 0);
    chk("R6 flags", int'(flags_o), 0);
    chk("R6 irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    cycle();
    chk("R6 irq masked after reset", int'(irq_o), 0);
    rx_one = 1'b0; rx_two = 1'b0;

    // R2: enable written while already empty
    wr_ctrl(4'b0001);
    chk("R10 ctrl readback", int'(ctrl_o), 1);
    chk("R2 enable after empty", int'(irq_o), 1);
    tx_empty = 1'b0; settle();
    chk("R2 level drops", int'(irq_o), 0);
    cycle();
    tx_empty = 1'b1; settle();
    chk("R2 empty after enable", int'(irq_o), 1);
    cycle();
    tx_empty = 1'b0;

    // R3: one-character threshold
    wr_ctrl(4'b0010);
    rx_one = 1'b1; settle();
    chk("R3 one char", int'(irq_o), 1);
    cycle();

    // R4: two-character threshold
    wr_ctrl(4'b1010);
    chk("R4 one char only", int'(irq_o), 0);
    rx_two = 1'b1; settle();
    chk("R4 two chars", int'(irq_o), 1);
    cycle();
    rx_one = 1'b0; rx_two = 1'b0;

    // R5 / R7: error flag set and hold
    wr_ctrl(4'b0100);
    set = 3'b010;
    settle();
    chk("R5 no irq before flag", int'(irq_o), 0);
    cycle();
    set = '0;
    chk("R7 framing flag set", int'(flags_o), 3'b010);
    chk("R5 irq with flag", int'(irq_o), 1);
    repeat (3) cycle();
    chk("R7 flag held", int'(flags_o), 3'b010);

    // R8: zero bits in the clear mask leave flags alone
    clr_we = 1'b1; clr = 3'b101;
    cycle();
    clr_we = 1'b0;
    chk("R8 masked clear", int'(flags_o), 3'b010);
    clr_we = 1'b1; clr = 3'b010;
    cycle();
    clr_we = 1'b0;
    chk("R8 bit cleared", int'(flags_o), 0);
    chk("R5 irq gone", int'(irq_o), 0);

    // R9: set and clear collide
    set = 3'b001; clr_we = 1'b1; clr = 3'b001;
    cycle();
    set = '0; clr_we = 1'b0;
    chk("R9 set wins", int'(flags_o), 3'b001);

    // R1: several causes, drop one at a time
    wr_ctrl(4'b0111);
    tx_empty = 1'b1; rx_one = 1'b1; settle();
    chk("R1 all causes", int'(irq_o), 1);
    tx_empty = 1'b0; settle();
    chk("R1 two left", int'(irq_o), 1);
    rx_one = 1'b0; settle();
    chk("R1 error left", int'(irq_o), 1);
    clr_we = 1'b1; clr = 3'b111;
    cycle();
    clr_we = 1'b0;
    chk("R1 none left", int'(irq_o), 0);

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      ctrl_we    = ($urandom_range(0, 7) == 0);
      ctrl_wdata = 4'($urandom);
      clr_we     = ($urandom_range(0, 3) == 0);
      clr        = 3'($urandom);
      set        = ($urandom_range(0, 4) == 0) ? 3'($urandom) : '0;
      tx_empty   = 1'($urandom);
      rx_one     = 1'($urandom);
      rx_two     = rx_one & 1'($urandom);
      cycle();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule